// File: doc/BRIEF.md
# BCD Clock Register Access Sequencer

This block runs whole time-of-day transactions against a clock device whose registers hold one decimal digit each. It sits above a nibble register bus master. That master serialises single 4-bit register reads and writes. The sequencer drives the device chip enable and wins the device's busy handshake before every transaction. It then walks the digit registers in a fixed order. On the way it converts between binary host fields and BCD digit pairs, in both directions.

A host asks for a read or a set of the full date and time through a valid/ready command channel. The block returns the result through a valid/ready response channel. The command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the block is idle. A response stays on the port with stable contents until the host raises `rsp_ready`. No new command is taken before that. The response handshake marks the end of a transaction.

After reset, the block first checks the device for a stopped oscillator. If the device reports one, the block repairs it and loads a fixed date before it accepts any command.

Top module: `rtc_txn_seq`

## Requirements
- R1: After reset, the first bus access is a read of the control register (address 0xE) with `rtc_ce` high. `cmd_ready` stays low until the start-up check has finished.
- R2: Start-up recovery runs when bit 1 of that first control read is set. It then writes 0x0 to address 0x7 and 0x7 to address 0xE, and reads 0xE until bit 0 reads clear. After that it writes the following date through a normal set transaction: seconds, minutes, hours and weekday 0, day 1, stored month 2, year 00. When bit 1 reads clear, no write reaches the device.
- R3: Every host transaction begins with a write of 0x4 to address 0xE followed by a read of 0xE. If bit 0 of that read is set, `rtc_ce` drops and the handshake is retried.
- R4: After RETRY_MAX busy readings in one busy loop, the transaction is abandoned. No digit register is accessed, and the response carries `rsp_err` = 1. `rsp_err` is cleared when the next command is accepted.
- R5: Digit registers are accessed in this address order: 0,1,2,3,4,5,8,9,A,B,C,D,6. This is seconds, minutes, hours, day, month, year and weekday, with each units digit before its tens digit.
- R6: On a set, each field is written as BCD. The units digit goes to the even address and the tens digit to the odd address above it. The month is stored as the host value plus 1, and the year is stored modulo 100.
- R7: On a read, each field is returned as tens*10+units. The month is reduced by 1. A year value below 70 has 100 added.
- R8: `bus_req` is high only while `rtc_ce` is high. Between two high periods, `rtc_ce` stays low for at least GAP_CYCLES cycles.
- R9: `bus_req` stays high, with stable `bus_wr`, `bus_addr` and `bus_wdata`, until the cycle in which `bus_ack` is high. `bus_rdata` is taken in that cycle.
- R10: `cmd_ready` is never high together with `rsp_valid` or `rtc_ce`. `rsp_valid` and the response fields hold until `rsp_ready`. A command that arrives during start-up waits until the recovery writes are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_write | input | 1 | 1 = set time, 0 = read time |
| cmd_sec | input | 8 | Seconds to set, 0..59 |
| cmd_min | input | 8 | Minutes to set, 0..59 |
| cmd_hour | input | 8 | Hours to set, 0..23 |
| cmd_mday | input | 8 | Day of month to set, 1..31 |
| cmd_mon | input | 8 | Month index to set, 0..11 |
| cmd_year | input | 8 | Years since 1900, 0..255 |
| cmd_wday | input | 3 | Weekday to set, 0..6 |
| rsp_valid | output | 1 | Transaction finished, response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_err | output | 1 | Busy retry limit reached |
| rsp_sec | output | 8 | Seconds read |
| rsp_min | output | 8 | Minutes read |
| rsp_hour | output | 8 | Hours read |
| rsp_mday | output | 8 | Day of month read |
| rsp_mon | output | 8 | Month index read |
| rsp_year | output | 8 | Years since 1900 read |
| rsp_wday | output | 3 | Weekday read |
| rtc_ce | output | 1 | Device chip enable |
| bus_req | output | 1 | Register access request |
| bus_wr | output | 1 | 1 = register write |
| bus_addr | output | 4 | Register address |
| bus_wdata | output | 4 | Write nibble |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 4 | Read nibble, valid with `bus_ack` |

## Verification
The start-up recovery and a host read request can fall due in the same cycle. To provoke this, the bench holds `cmd_valid` high from the release of reset while the device model reports a stopped oscillator. It then judges two things. The command must be taken only after the fixed-date writes are already in the model's registers. The read must return that fixed date. A second pairing is the busy handshake against the retry limit. The model is kept busy for more readings than the limit allows. The bench then checks that the response carries the error flag and that no digit address appears on the bus.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

  typedef enum logic [3:0] {
    ST_START,
    ST_BOOT_RD,
    ST_BOOT_INT,
    ST_BOOT_CTL,
    ST_BOOT_POLL,
    ST_HS_CTL,
    ST_HS_RD,
    ST_HS_GAP,
    ST_XFER,
    ST_GAP,
    ST_RSP,
    ST_IDLE
  } seq_state_t;

  localparam logic [3:0] ADDR_CTRL = 4'hE;
  localparam logic [3:0] ADDR_IRQ  = 4'h7;
  localparam logic [3:0] ADDR_WDAY = 4'h6;

  localparam logic [3:0] CTRL_H24  = 4'h4;
  localparam logic [3:0] CTRL_FIX  = 4'h7;
  localparam logic [3:0] IRQ_OFF   = 4'h0;

  localparam int BIT_BUSY = 0;
  localparam int BIT_STOP = 1;

  localparam int FIELD_W = 8;
  localparam int N_PAIR  = 6;
  localparam int N_SLOT  = 2 * N_PAIR + 1;

  function automatic logic [3:0] slot_addr(input logic [3:0] k);
    if (k == 4'(N_SLOT - 1)) return ADDR_WDAY;
    else if (k < 4'd6) return k;
    else return k + 4'd2;
  endfunction

endpackage

// File: rtl/rtc_bcd_enc.sv
module rtc_bcd_enc #(
  parameter int BIN_W = 8
) (
  input  logic [BIN_W-1:0] bin,
  output logic [3:0]       tens,
  output logic [3:0]       units
);
  localparam int SHIFT  = 11;
  localparam int PROD_W = BIN_W + 8;

  logic [PROD_W-1:0] prod;
  logic [3:0]        q;
  logic [BIN_W-1:0]  q_x10;
  logic [BIN_W-1:0]  rem;

  always_comb begin
    prod  = PROD_W'(bin) * PROD_W'(205);
    q     = prod[SHIFT+3:SHIFT];
    q_x10 = BIN_W'(q) * BIN_W'(10);
    rem   = bin - q_x10;
    tens  = q;
    units = rem[3:0];
  end
endmodule

// File: rtl/rtc_bcd_dec.sv
module rtc_bcd_dec #(
  parameter int BIN_W = 8
) (
  input  logic [3:0]       tens,
  input  logic [3:0]       units,
  output logic [BIN_W-1:0] bin
);
  always_comb bin = BIN_W'(tens) * BIN_W'(10) + BIN_W'(units);
endmodule

// File: rtl/rtc_gap_timer.sv
module rtc_gap_timer #(
  parameter int CYCLES = 88
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_txn_seq.sv
module rtc_txn_seq
  import rtc_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 88,
  parameter int RETRY_MAX  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_write,
  input  logic [7:0] cmd_sec,
  input  logic [7:0] cmd_min,
  input  logic [7:0] cmd_hour,
  input  logic [7:0] cmd_mday,
  input  logic [7:0] cmd_mon,
  input  logic [7:0] cmd_year,
  input  logic [2:0] cmd_wday,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic       rsp_err,
  output logic [7:0] rsp_sec,
  output logic [7:0] rsp_min,
  output logic [7:0] rsp_hour,
  output logic [7:0] rsp_mday,
  output logic [7:0] rsp_mon,
  output logic [7:0] rsp_year,
  output logic [2:0] rsp_wday,
  output logic       rtc_ce,
  output logic       bus_req,
  output logic       bus_wr,
  output logic [3:0] bus_addr,
  output logic [3:0] bus_wdata,
  input  logic       bus_ack,
  input  logic [3:0] bus_rdata
);
  localparam int         RC_W      = $clog2(RETRY_MAX + 1);
  localparam logic [3:0] LAST_SLOT = 4'(N_SLOT - 1);

  seq_state_t state;
  logic [3:0]      slot;
  logic [RC_W-1:0] rcnt;
  logic            is_wr, is_boot, err;
  logic [FIELD_W-1:0] w_bin [N_PAIR];
  logic [2:0]      w_wday;
  logic [3:0]      rd_nib [N_SLOT];

  logic [3:0] enc_t [N_PAIR];
  logic [3:0] enc_u [N_PAIR];
  logic [FIELD_W-1:0] dec_bin [N_PAIR];

  logic       gap_run, gap_done;
  logic       acc_en, acc_wr;
  logic [3:0] acc_addr, acc_wdata, slot_wd;
  logic [7:0] yr_mod;
  logic       busy_seen, stop_seen, retry_last, cmd_fire;

  // digit codecs, one per field pair
  for (genvar i = 0; i < N_PAIR; i++) begin : g_codec
    rtc_bcd_enc #(.BIN_W(FIELD_W)) u_enc (
      .bin  (w_bin[i]),
      .tens (enc_t[i]),
      .units(enc_u[i])
    );
    rtc_bcd_dec #(.BIN_W(FIELD_W)) u_dec (
      .tens (rd_nib[2*i+1]),
      .units(rd_nib[2*i]),
      .bin  (dec_bin[i])
    );
  end

  assign gap_run = (state == ST_GAP) || (state == ST_HS_GAP);

  rtc_gap_timer #(.CYCLES(GAP_CYCLES)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (gap_run),
    .expired(gap_done)
  );

  always_comb begin
    if (cmd_year >= 8'd200)      yr_mod = cmd_year - 8'd200;
    else if (cmd_year >= 8'd100) yr_mod = cmd_year - 8'd100;
    else                         yr_mod = cmd_year;
  end

  always_comb begin
    if (slot == LAST_SLOT) slot_wd = {1'b0, w_wday};
    else if (slot[0])      slot_wd = enc_t[slot[3:1]];
    else                   slot_wd = enc_u[slot[3:1]];
  end

  // access decode from state
  always_comb begin
    acc_en    = 1'b0;
    acc_wr    = 1'b0;
    acc_addr  = ADDR_CTRL;
    acc_wdata = 4'h0;
    unique case (state)
      ST_BOOT_RD, ST_BOOT_POLL, ST_HS_RD: acc_en = 1'b1;
      ST_BOOT_INT: begin
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = ADDR_IRQ; acc_wdata = IRQ_OFF;
      end
      ST_BOOT_CTL: begin
        acc_en = 1'b1; acc_wr = 1'b1; acc_wdata = CTRL_FIX;
      end
      ST_HS_CTL: begin
        acc_en = 1'b1; acc_wr = 1'b1; acc_wdata = CTRL_H24;
      end
      ST_XFER: begin
        acc_en = 1'b1; acc_wr = is_wr; acc_addr = slot_addr(slot); acc_wdata = slot_wd;
      end
      default: ;
    endcase
  end

  assign bus_req   = acc_en;
  assign bus_wr    = acc_wr;
  assign bus_addr  = acc_addr;
  assign bus_wdata = acc_wdata;

  assign rtc_ce = !((state == ST_START) || (state == ST_HS_GAP) || (state == ST_GAP) ||
                    (state == ST_RSP) || (state == ST_IDLE));

  assign cmd_ready  = (state == ST_IDLE);
  assign cmd_fire   = cmd_ready && cmd_valid;
  assign rsp_valid  = (state == ST_RSP);
  assign rsp_err    = err;
  assign busy_seen  = bus_rdata[BIT_BUSY];
  assign stop_seen  = bus_rdata[BIT_STOP];
  assign retry_last = (rcnt == RC_W'(RETRY_MAX - 1));

  assign rsp_sec  = dec_bin[0];
  assign rsp_min  = dec_bin[1];
  assign rsp_hour = dec_bin[2];
  assign rsp_mday = dec_bin[3];
  assign rsp_mon  = dec_bin[4] - 8'd1;
  assign rsp_year = (dec_bin[5] < 8'd70) ? dec_bin[5] + 8'd100 : dec_bin[5];
  assign rsp_wday = rd_nib[N_SLOT-1][2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_START;
      slot    <= '0;
      rcnt    <= '0;
      is_wr   <= 1'b0;
      is_boot <= 1'b1;
      err     <= 1'b0;
      w_wday  <= '0;
      for (int i = 0; i < N_PAIR; i++) w_bin[i] <= '0;
      for (int i = 0; i < N_SLOT; i++) rd_nib[i] <= '0;
    end else begin
      unique case (state)
        ST_START: state <= ST_BOOT_RD;
        ST_BOOT_RD: if (bus_ack) state <= stop_seen ? ST_BOOT_INT : ST_GAP;
        ST_BOOT_INT: if (bus_ack) state <= ST_BOOT_CTL;
        ST_BOOT_CTL: if (bus_ack) state <= ST_BOOT_POLL;
        ST_BOOT_POLL: if (bus_ack) begin
          if (!busy_seen) begin
            state    <= ST_HS_CTL;
            rcnt     <= '0;
            is_wr    <= 1'b1;
            w_bin[0] <= 8'd0;
            w_bin[1] <= 8'd0;
            w_bin[2] <= 8'd0;
            w_bin[3] <= 8'd1;
            w_bin[4] <= 8'd2;
            w_bin[5] <= 8'd0;
            w_wday   <= 3'd0;
          end else if (retry_last) begin
            err   <= 1'b1;
            state <= ST_GAP;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        ST_HS_CTL: if (bus_ack) state <= ST_HS_RD;
        ST_HS_RD: if (bus_ack) begin
          if (!busy_seen) begin
            state <= ST_XFER;
            slot  <= '0;
          end else if (retry_last) begin
            err   <= 1'b1;
            state <= ST_GAP;
          end else begin
            rcnt  <= rcnt + 1'b1;
            state <= ST_HS_GAP;
          end
        end
        ST_HS_GAP: if (gap_done) state <= ST_HS_CTL;
        ST_XFER: if (bus_ack) begin
          if (!is_wr) rd_nib[slot] <= bus_rdata;
          if (slot == LAST_SLOT) state <= ST_GAP;
          else slot <= slot + 4'd1;
        end
        ST_GAP: if (gap_done) begin
          if (is_boot) begin
            is_boot <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            state <= ST_RSP;
          end
        end
        ST_RSP: if (rsp_ready) state <= ST_IDLE;
        ST_IDLE: if (cmd_fire) begin
          state    <= ST_HS_CTL;
          err      <= 1'b0;
          rcnt     <= '0;
          is_wr    <= cmd_write;
          w_bin[0] <= cmd_sec;
          w_bin[1] <= cmd_min;
          w_bin[2] <= cmd_hour;
          w_bin[3] <= cmd_mday;
          w_bin[4] <= cmd_mon + 8'd1;
          w_bin[5] <= yr_mod;
          w_wday   <= cmd_wday;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_txn_seq_chk.sv
module rtc_txn_seq_chk #(
  parameter int GAP_CYCLES = 88
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rtc_ce,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [3:0]  bus_wdata,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [51:0] rsp_pack
);
  localparam int LC_W = $clog2(GAP_CYCLES + 1);

  logic [LC_W-1:0] low_cnt;
  logic            seen_hi, ce_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      seen_hi <= 1'b0;
      ce_prev <= 1'b0;
    end else begin
      ce_prev <= rtc_ce;
      if (rtc_ce) begin
        seen_hi <= 1'b1;
        low_cnt <= '0;
      end else if (low_cnt != LC_W'(GAP_CYCLES)) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  p_req_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> rtc_ce);

  p_ce_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_ce && !ce_prev && seen_hi) |-> (low_cnt >= LC_W'(GAP_CYCLES)));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr) &&
                              $stable(bus_wdata)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pack)));

  p_idle_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!rsp_valid && !rtc_ce));

  p_ctrl_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_ce && !ce_prev) |-> (bus_req && bus_addr == 4'hE));
endmodule

bind rtc_txn_seq rtc_txn_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rtc_ce   (rtc_ce),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_pack ({rsp_err, rsp_sec, rsp_min, rsp_hour, rsp_mday, rsp_mon, rsp_year, rsp_wday})
);

// File: tb/test_rtc_txn_seq.sv
`timescale 1ns/1ps
module test_rtc_txn_seq;
  localparam int GAP = 88;
  localparam int RMAX = 8;
  localparam int LOGN = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_write = 0, rsp_ready = 0;
  logic [7:0] cmd_sec = 0, cmd_min = 0, cmd_hour = 0, cmd_mday = 0, cmd_mon = 0, cmd_year = 0;
  logic [2:0] cmd_wday = 0;
  logic cmd_ready, rsp_valid, rsp_err, rtc_ce, bus_req, bus_wr;
  logic [7:0] rsp_sec, rsp_min, rsp_hour, rsp_mday, rsp_mon, rsp_year;
  logic [2:0] rsp_wday;
  logic [3:0] bus_addr, bus_wdata;
  logic bus_ack;
  logic [3:0] bus_rdata;

  rtc_txn_seq #(.GAP_CYCLES(GAP), .RETRY_MAX(RMAX)) i_rtc_txn_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_sec(cmd_sec), .cmd_min(cmd_min), .cmd_hour(cmd_hour),
    .cmd_mday(cmd_mday), .cmd_mon(cmd_mon), .cmd_year(cmd_year), .cmd_wday(cmd_wday),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_sec(rsp_sec), .rsp_min(rsp_min), .rsp_hour(rsp_hour), .rsp_mday(rsp_mday),
    .rsp_mon(rsp_mon), .rsp_year(rsp_year), .rsp_wday(rsp_wday), .rtc_ce(rtc_ce),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  // device model
  logic       cfg_stop = 1'b1;
  int         busy_cfg = 0;
  logic       busy_arm = 1'b0;
  logic [3:0] mem [16];
  logic       stopped;
  int         busy_left, lat;
  int         log_n = 0;
  logic [4:0] log_a [LOGN];
  logic       ack_q = 1'b0;
  logic [3:0] rdat_q = 4'h0;
  logic       ce_d = 1'b0;
  int         ce_rises = 0;

  assign bus_ack = ack_q;
  assign bus_rdata = rdat_q;

  always @(posedge clk) begin
    ce_d <= rtc_ce;
    if (rtc_ce && !ce_d) ce_rises <= ce_rises + 1;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 4'h5;
      stopped <= cfg_stop;
      busy_left <= 0;
      lat <= 0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (busy_arm) busy_left <= busy_cfg;
      if (bus_req && !ack_q) begin
        if (lat < 2) lat <= lat + 1;
        else begin
          lat <= 0;
          ack_q <= 1'b1;
          log_a[log_n % LOGN] <= {bus_wr, bus_addr};
          log_n <= log_n + 1;
          if (bus_wr) begin
            if (bus_addr == 4'hE) begin
              if (bus_wdata[1:0] == 2'b11) stopped <= 1'b0;
            end else mem[bus_addr] <= bus_wdata;
          end else if (bus_addr == 4'hE) begin
            rdat_q <= {2'b00, stopped, busy_left > 0};
            if (busy_left > 0) busy_left <= busy_left - 1;
          end else rdat_q <= mem[bus_addr];
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  logic [7:0] r_sec, r_min, r_hour, r_mday, r_mon, r_year;
  logic [2:0] r_wday;
  logic r_err;

  task automatic run_cmd(input bit wr, input logic [7:0] s, m, h, d, mo, y, input logic [2:0] wd);
    @(negedge clk);
    cmd_write = wr; cmd_sec = s; cmd_min = m; cmd_hour = h; cmd_mday = d;
    cmd_mon = mo; cmd_year = y; cmd_wday = wd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_sec = rsp_sec; r_min = rsp_min; r_hour = rsp_hour; r_mday = rsp_mday;
    r_mon = rsp_mon; r_year = rsp_year; r_wday = rsp_wday; r_err = rsp_err;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic do_reset(input bit stop);
    cfg_stop = stop;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  localparam logic [3:0] ORDER [13] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8,
                                        4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'h6};
  // sec, min, hour, mday, mon, year, wday, expected year
  localparam logic [63:0] VEC [4] = '{
    {8'd0,  8'd0,  8'd0,  8'd1,  8'd0,  8'd100, 8'd0, 8'd100},
    {8'd59, 8'd59, 8'd23, 8'd31, 8'd11, 8'd199, 8'd6, 8'd99},
    {8'd30, 8'd45, 8'd12, 8'd15, 8'd5,  8'd69,  8'd3, 8'd169},
    {8'd7,  8'd8,  8'd9,  8'd10, 8'd9,  8'd170, 8'd5, 8'd70}
  };

  initial begin
    int base, nw, ne;
    bit ok;
    // start-up with stopped oscillator and a read request already pending
    cfg_stop = 1'b1;
    base = log_n;
    rst_n = 1'b0;
    cmd_valid = 1'b1; cmd_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1", "cmd_ready after reset", cmd_ready, 0);
    while (log_n == base) @(negedge clk);
    chk(log_a[base % LOGN] == 5'h0E, "R1", "first access read ctrl", log_a[base % LOGN], 5'h0E);
    while (!cmd_ready) @(negedge clk);
    chk(log_a[(base + 1) % LOGN] == 5'h17, "R2", "irq off write", log_a[(base + 1) % LOGN], 5'h17);
    chk(log_a[(base + 2) % LOGN] == 5'h1E, "R2", "ctrl fix write", log_a[(base + 2) % LOGN], 5'h1E);
    chk(mem[7] == 4'h0, "R2", "irq register", mem[7], 0);
    chk(mem[8] == 4'h1 && mem[10] == 4'h2, "R10", "boot writes done before command",
        {mem[8], mem[10]}, 8'h12);
    cmd_valid = 1'b0;
    run_cmd(1'b0, 0, 0, 0, 0, 0, 0, 0);
    chk(r_sec == 0 && r_min == 0 && r_hour == 0 && r_wday == 0, "R2", "boot time zero",
        {r_sec, r_min, r_hour}, 0);
    chk(r_mday == 1, "R2", "boot day", r_mday, 1);
    chk(r_mon == 1, "R7", "boot month index", r_mon, 1);
    chk(r_year == 100, "R7", "boot year", r_year, 100);

    // vector table: set then read back
    for (int v = 0; v < 4; v++) begin
      run_cmd(1'b1, VEC[v][63:56], VEC[v][55:48], VEC[v][47:40], VEC[v][39:32],
              VEC[v][31:24], VEC[v][23:16], VEC[v][10:8]);
      if (v == 1) begin
        chk(mem[0] == 9 && mem[1] == 5, "R6", "seconds digits", {mem[1], mem[0]}, 8'h59);
        chk(mem[10] == 2 && mem[11] == 1, "R6", "month stored plus one", {mem[11], mem[10]}, 8'h12);
        chk(mem[12] == 9 && mem[13] == 9, "R6", "year modulo 100", {mem[13], mem[12]}, 8'h99);
        chk(mem[6] == 6, "R6", "weekday", mem[6], 6);
      end
      base = log_n;
      run_cmd(1'b0, 0, 0, 0, 0, 0, 0, 0);
      ok = (r_sec == VEC[v][63:56]) && (r_min == VEC[v][55:48]) && (r_hour == VEC[v][47:40]) &&
           (r_mday == VEC[v][39:32]) && (r_wday == VEC[v][10:8]);
      chk(ok, "R7", "read back fields", {r_sec, r_min, r_hour, r_mday}, VEC[v][63:32]);
      chk(r_mon == VEC[v][31:24], "R7", "read back month", r_mon, VEC[v][31:24]);
      chk(r_year == VEC[v][7:0], "R7", "read back year", r_year, VEC[v][7:0]);
      if (v == 0) begin
        chk(log_a[base % LOGN] == 5'h1E && log_a[(base + 1) % LOGN] == 5'h0E, "R3",
            "handshake write then read", log_a[base % LOGN], 5'h1E);
        ok = 1'b1;
        for (int k = 0; k < 13; k++)
          if (log_a[(base + 2 + k) % LOGN] != {1'b0, ORDER[k]}) ok = 1'b0;
        chk(ok, "R5", "digit access order", log_n - base, 15);
      end
    end

    // busy retry path
    @(negedge clk); busy_cfg = 2; busy_arm = 1'b1; @(negedge clk); busy_arm = 1'b0;
    base = log_n; ne = ce_rises;
    run_cmd(1'b0, 0, 0, 0, 0, 0, 0, 0);
    nw = 0;
    for (int i = base; i < log_n; i++) if (log_a[i % LOGN] == 5'h1E) nw++;
    chk(nw == 3, "R3", "handshake attempts", nw, 3);
    chk(ce_rises - ne == 3, "R3", "ce high periods", ce_rises - ne, 3);
    chk(r_err == 1'b0 && r_year == 70, "R3", "result after retry", r_year, 70);

    // retry limit
    @(negedge clk); busy_cfg = 50; busy_arm = 1'b1; @(negedge clk); busy_arm = 1'b0;
    base = log_n;
    run_cmd(1'b0, 0, 0, 0, 0, 0, 0, 0);
    chk(r_err == 1'b1, "R4", "error flag", r_err, 1);
    nw = 0; ne = 0;
    for (int i = base; i < log_n; i++) begin
      if (log_a[i % LOGN] == 5'h1E) nw++;
      if (log_a[i % LOGN][3:0] != 4'hE) ne++;
    end
    chk(nw == RMAX, "R4", "handshake count at limit", nw, RMAX);
    chk(ne == 0, "R4", "no digit access", ne, 0);
    @(negedge clk); busy_cfg = 0; busy_arm = 1'b1; @(negedge clk); busy_arm = 1'b0;
    run_cmd(1'b0, 0, 0, 0, 0, 0, 0, 0);
    chk(r_err == 1'b0, "R4", "error cleared", r_err, 0);

    // response back-pressure
    @(negedge clk);
    cmd_write = 1'b0; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_year = rsp_year;
    repeat (10) @(negedge clk);
    chk(rsp_valid && !cmd_ready, "R10", "response held", rsp_valid, 1);
    chk(rsp_year == r_year, "R10", "response stable", rsp_year, r_year);
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    chk(!rsp_valid && cmd_ready, "R10", "response released", rsp_valid, 0);

    // start-up with running oscillator: no writes
    base = log_n;
    do_reset(1'b0);
    while (!cmd_ready) @(negedge clk);
    chk(log_n - base == 1, "R2", "single start-up access", log_n - base, 1);
    chk(log_a[base % LOGN] == 5'h0E, "R1", "start-up control read", log_a[base % LOGN], 5'h0E);
    run_cmd(1'b0, 0, 0, 0, 0, 0, 0, 0);
    chk(r_sec == 55 && r_mday == 55, "R7", "preset digits", r_sec, 55);
    chk(r_mon == 54, "R7", "preset month", r_mon, 54);
    chk(r_year == 155 && r_wday == 5, "R7", "preset year", r_year, 155);
    summary();
  end
endmodule